// File: doc/BRIEF.md
# Printer Port Register Block with Emulated Handshake

This block presents a byte-wide host register window for a legacy printer port. A host reads and writes an output data byte, a status byte and a control byte over a simple synchronous bus with one access per clock. No printer is attached. The block emulates one internally, so the busy and acknowledge status bits move through a fixed handshake sequence as the host toggles the strobe control bit and polls status.

When the host raises the strobe bit while select and init are both asserted, the byte held in the output data register leaves on a one-cycle valid/data stream. This is the point where a downstream consumer takes printed characters. A level interrupt output reports a pending event that the host arms through the control interrupt-enable bit. A status poll acknowledges the event.

Read data is combinational during the access cycle by default. A parameter can add one register stage. Register side effects take effect at the clock edge that ends the access.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, offset 0 reads 0xFF, offset 1 (status) reads 0xD8, offset 2 (control) reads 0x0C, and both `irq` and `tx_valid` are 0.
- R2: Only the low three address bits select a register: offset 0 is data, 1 is status, 2 is control, and an address such as 0x08 aliases offset 0. Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R3: A data read returns the input-data register when control bit 5 (direction) is 1. Otherwise it returns the last byte written to offset 0. The input-data register captures `pin_din` every clock and resets to 0xFF.
- R4: A control write with bit 2 (init) at 0 loads status with 0xD8: bit 7 not-busy, bit 6 acknowledge, bit 4 online and bit 3 not-error all set.
- R5: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all set clears status bit 7. If the previously stored strobe bit was 0, it also emits the current output data byte: `tx_valid` is high for exactly the one cycle after the write edge, with `tx_data` equal to that byte.
- R6: A control write with init and select set and strobe clear sets the interrupt-pending flag when the previously stored control bit 4 (interrupt enable) is 1. `irq` shows the flag from the edge that ends the access.
- R7: A status read returns the status value held before the access and clears the interrupt-pending flag, so `irq` is 0 after that edge.
- R8: A status read taken while status bit 7 is 0 and stored strobe is 0 advances the handshake. If bit 6 is set, it is cleared. Otherwise bits 7 and 6 are both set. In any other case a status read leaves status unchanged.
- R9: A control write stores all eight bits, and a later control read returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address; low three bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_din | input | 8 | Byte presented to the input-data register |
| tx_valid | output | 1 | One-cycle pulse per emitted byte |
| tx_data | output | 8 | Emitted byte, held until the next emission |
| irq | output | 1 | Level interrupt, high while an event is pending |

## Verification
The data path is swept over every byte value and every offset, including aliased addresses. This separates decode faults from storage faults. The handshake is driven through full strobe-high, strobe-low and poll sequences, and the status value is followed through 0x58, 0x18 and 0xD8. That sequence tells the acknowledge-clear step apart from the busy-and-acknowledge-set step. Repeated strobe-high writes, and writes with select or init cleared, confirm that a byte is emitted only on a stored strobe edge under the right conditions. The interrupt is armed once with enable newly set and once with enable already stored, which shows that the old control value is the one compared.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd1;
   localparam logic [2:0] OFS_CTRL = 3'd2;

   // status bit positions
   localparam int unsigned ST_NBUSY = 7;
   localparam int unsigned ST_ACK   = 6;

   // control bit positions
   localparam int unsigned CT_DIR = 5;
   localparam int unsigned CT_IEN = 4;
   localparam int unsigned CT_SEL = 3;
   localparam int unsigned CT_INI = 2;
   localparam int unsigned CT_STB = 0;

   localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hD8;
   localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h0C;
   localparam logic [BYTE_W-1:0] DATA_RST  = 8'hFF;
   localparam logic [BYTE_W-1:0] OPEN_BUS  = 8'hFF;

   typedef struct packed {
      logic load_idle;
      logic clr_busy;
      logic emit;
      logic set_pend;
   } ctrl_evt_t;
endpackage

// File: rtl/prn_ctrl_unit.sv
module prn_ctrl_unit
   import prn_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] ctrl_q,
   output ctrl_evt_t         evt
);
   logic armed;

   // decisions use the stored value; the new value lands at the same edge
   always_comb begin
      armed         = wr_ctrl && wdata[CT_INI] && wdata[CT_SEL];
      evt.load_idle = wr_ctrl && !wdata[CT_INI];
      evt.clr_busy  = armed && wdata[CT_STB];
      evt.emit      = armed && wdata[CT_STB] && !ctrl_q[CT_STB];
      evt.set_pend  = armed && !wdata[CT_STB] && ctrl_q[CT_IEN];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (wr_ctrl) ctrl_q <= wdata;
   end
endmodule

// File: rtl/prn_status_model.sv
module prn_status_model
   import prn_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_idle,
   input  logic              clr_busy,
   input  logic              poll,
   input  logic              strobe_now,
   output logic [BYTE_W-1:0] status_q
);
   logic advance;

   assign advance = poll && !status_q[ST_NBUSY] && !strobe_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= STAT_IDLE;
      end else if (load_idle) begin
         status_q <= STAT_IDLE;
      end else if (clr_busy) begin
         status_q[ST_NBUSY] <= 1'b0;
      end else if (advance) begin
         if (status_q[ST_ACK]) begin
            status_q[ST_ACK] <= 1'b0;
         end else begin
            status_q[ST_ACK]   <= 1'b1;
            status_q[ST_NBUSY] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
   import prn_port_pkg::*;
#(
   parameter int unsigned BUS_AW     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter bit          RDATA_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pin_din,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              irq
);
   localparam int unsigned DEC_W = 3;

   initial begin
      if (DATA_W != BYTE_W) $fatal(1, "prn_port_regs: DATA_W must be 8");
      if (BUS_AW < DEC_W)   $fatal(1, "prn_port_regs: BUS_AW below 3");
   end

   logic [DEC_W-1:0]  ofs;
   logic              wr_data, wr_ctrl, rd_stat;
   logic [BYTE_W-1:0] dout_q, din_q, ctrl_q, status_q, rd_mux;
   logic              pend_q;
   ctrl_evt_t         evt;

   assign ofs     = bus_addr[DEC_W-1:0];
   assign wr_data = bus_en &&  bus_we && (ofs == OFS_DATA);
   assign wr_ctrl = bus_en &&  bus_we && (ofs == OFS_CTRL);
   assign rd_stat = bus_en && !bus_we && (ofs == OFS_STAT);

   prn_ctrl_unit u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q),
      .evt     (evt)
   );

   prn_status_model u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_idle  (evt.load_idle),
      .clr_busy   (evt.clr_busy),
      .poll       (rd_stat),
      .strobe_now (ctrl_q[CT_STB]),
      .status_q   (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= DATA_RST;
         din_q  <= DATA_RST;
      end else begin
         din_q <= pin_din;
         if (wr_data) dout_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_q <= 1'b0;
      else if (evt.set_pend) pend_q <= 1'b1;
      else if (rd_stat)      pend_q <= 1'b0;
   end
   assign irq = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= DATA_RST;
      end else begin
         tx_valid <= evt.emit;
         if (evt.emit) tx_data <= dout_q;
      end
   end

   always_comb begin
      unique case (ofs)
         OFS_DATA: rd_mux = ctrl_q[CT_DIR] ? din_q : dout_q;
         OFS_STAT: rd_mux = status_q;
         OFS_CTRL: rd_mux = ctrl_q;
         default:  rd_mux = OPEN_BUS;
      endcase
   end

   generate
      if (RDATA_FLOP) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                bus_rdata <= OPEN_BUS;
            else if (bus_en && !bus_we) bus_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate
endmodule

module prn_port_regs_chk #(
   parameter int unsigned BUS_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              tx_valid,
   input logic              irq,
   input logic [7:0]        status_q
);
   logic ctrl_wr, stat_rd;
   assign ctrl_wr = bus_en &&  bus_we && (bus_addr[2:0] == 3'd2);
   assign stat_rd = bus_en && !bus_we && (bus_addr[2:0] == 3'd1);

   AST_TX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid); // R5
   AST_TX_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(ctrl_wr && bus_wdata[0] && bus_wdata[2] && bus_wdata[3])); // R5
   AST_INIT_LOADS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !bus_wdata[2]) |=> (status_q == 8'hD8)); // R4
   AST_POLL_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !irq); // R7
   AST_IRQ_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctrl_wr && !bus_wdata[0] && bus_wdata[2] && bus_wdata[3])); // R6
endmodule

bind prn_port_regs prn_port_regs_chk #(.BUS_AW(BUS_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .tx_valid  (tx_valid),
   .irq       (irq),
   .status_q  (status_q)
);

// File: tb/prn_port_regs_tb.sv
module prn_port_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, pin_din = 8'h00;
   logic [7:0] bus_rdata, tx_data;
   logic       tx_valid, irq;

   int n_chk = 0, n_err = 0, tx_cnt = 0;
   logic [7:0] tx_last = 8'h00;
   logic       tx_prev = 1'b0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   prn_port_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_din(pin_din), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   always @(negedge clk) begin
      if (tx_valid) begin
         tx_cnt  = tx_cnt + 1;
         tx_last = tx_data;
         if (tx_prev) begin
            n_chk++; n_err++;
            $display("FAIL R5 tx_valid high two cycles: actual=1 expected=0");
         end
      end
      tx_prev = tx_valid;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_en = 1'b0;
   endtask

   initial begin
      #2000000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int c0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset values
      rd(8'h00, rv); check("R1 data", rv, 8'hFF);
      rd(8'h01, rv); check("R1 status", rv, 8'hD8);
      rd(8'h02, rv); check("R1 control", rv, 8'h0C);
      check("R1 irq", irq, 0);
      check("R1 tx_valid", tx_valid, 0);
      // R2 open offsets, all aliases
      for (int b = 0; b < 256; b += 8)
         for (int o = 3; o < 8; o++) begin
            rd(8'(b + o), rv); check("R2 open offset", rv, 8'hFF);
         end
      // R3/R2 data sweep via alias
      for (int i = 0; i < 256; i++) begin
         wr(8'(((i & 3) << 3)), 8'(i));
         rd(8'h00, rv); check("R3 data readback", rv, i);
      end
      wr(8'h00, 8'h33);
      wr(8'h05, 8'h77); wr(8'h01, 8'h00); wr(8'h0F, 8'h00);
      rd(8'h00, rv); check("R2 ignored write data", rv, 8'h33);
      rd(8'h02, rv); check("R2 ignored write ctrl", rv, 8'h0C);
      rd(8'h01, rv); check("R2 ignored write status", rv, 8'hD8);
      // R3 direction
      pin_din = 8'hA5;
      wr(8'h02, 8'h2C);
      rd(8'h00, rv); check("R3 input data", rv, 8'hA5);
      wr(8'h02, 8'h0C);
      rd(8'h00, rv); check("R3 output data", rv, 8'h33);
      // R5 strobe edge
      c0 = tx_cnt;
      wr(8'h02, 8'h0D);
      check("R5 tx_valid after edge", tx_valid, 1);
      check("R5 tx_data", tx_data, 8'h33);
      @(negedge clk); @(negedge clk);
      check("R5 one emission", tx_cnt - c0, 1);
      rd(8'h01, rv); check("R5 busy cleared", rv, 8'h58);
      rd(8'h02, rv); check("R9 control readback", rv, 8'h0D);
      wr(8'h02, 8'h0D);
      @(negedge clk); @(negedge clk);
      check("R5 no emit on held strobe", tx_cnt - c0, 1);
      rd(8'h01, rv); check("R8 no advance strobe high", rv, 8'h58);
      // R8 handshake
      wr(8'h02, 8'h0C);
      rd(8'h01, rv); check("R8 poll1", rv, 8'h58);
      rd(8'h01, rv); check("R8 poll2 ack cleared", rv, 8'h18);
      rd(8'h01, rv); check("R8 poll3 busy+ack set", rv, 8'hD8);
      rd(8'h01, rv); check("R8 steady", rv, 8'hD8);
      // R6 interrupt uses old enable
      wr(8'h02, 8'h1C); check("R6 no irq on new enable", irq, 0);
      wr(8'h02, 8'h1C); check("R6 irq set", irq, 1);
      rd(8'h00, rv); check("R6 irq held", irq, 1);
      rd(8'h01, rv); check("R7 status value", rv, 8'hD8);
      check("R7 irq cleared", irq, 0);
      // R4 init load
      wr(8'h00, 8'h99);
      c0 = tx_cnt;
      wr(8'h02, 8'h1D); check("R5 tx_data second", tx_data, 8'h99);
      rd(8'h01, rv); check("R4 pre status", rv, 8'h58);
      wr(8'h02, 8'h18);
      rd(8'h01, rv); check("R4 init loads idle", rv, 8'hD8);
      // R5 select clear: no emission
      wr(8'h02, 8'h04); wr(8'h02, 8'h05);
      @(negedge clk); @(negedge clk);
      check("R5 select low no emit", tx_cnt - c0, 1);
      rd(8'h01, rv); check("R5 select low status kept", rv, 8'hD8);
      rd(8'h02, rv); check("R9 control readback 2", rv, 8'h05);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule